// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block is the arbitration core of an eight-line interrupt controller. It holds three pieces of state: a request vector, an in-service vector and a three-bit priority offset. Each line is captured in edge or level mode. Every cycle the core finds the best-ranked pending request that is not masked. It raises its interrupt output only when that request outranks everything already in service.

The core does not own a host register file. The mask, the per-line trigger mode and the mode bits arrive as plain input ports. The same holds for the acknowledge, end-of-interrupt (EOI) and specific-EOI strobes. A controller that wraps the core drives these ports from its own decode. It uses the request and in-service vectors, which are brought out, for readback. The cascade line can be left out of the in-service comparison, so a downstream controller can interrupt through a line that is already in service.

Top module: `rpr_core`

## Requirements
- R1: An edge-mode line (`level_i[n]`=0) sets request bit n in the cycle after its input changes from 0 to 1 relative to the previous sample, and the bit stays set while the input stays high or falls. The first sample after reset compares against 0.
- R2: A level-mode line (`level_i[n]`=1) has request bit n equal to the input value sampled on the previous clock edge.
- R3: Priority rank k belongs to line (k + offset) mod 8, and rank 0 is the highest. `int_o` is 1 exactly when the best rank among requests with a mask bit of 0 is strictly lower than the best in-service rank. An empty set counts as rank 8.
- R4: With `ack_i`=1 while `int_o`=1, `ack_valid_o`=1 and `ack_idx_o` shows the line chosen under R3 in the same cycle. On the next edge that line's in-service bit is set and its request bit is cleared if it is edge-mode. With `ack_i`=1 while `int_o`=0, `ack_valid_o`=0 and no state changes from the strobe.
- R5: With `auto_eoi_i`=1 an accepted acknowledge leaves the in-service vector unchanged. If `rot_auto_i`=1 as well, the offset becomes (line + 1) mod 8.
- R6: `eoi_i` clears the best-ranked in-service bit, ranked over the full vector with the current offset. With `rot_eoi_i`=1 the offset becomes that line + 1 mod 8. With an empty in-service vector the strobe does nothing.
- R7: `seoi_i` clears in-service bit `seoi_idx_i`. With `rot_eoi_i`=1 the offset becomes `seoi_idx_i` + 1 mod 8.
- R8: With `nested_i`=1, in-service bit 2 (the cascade line) is excluded from the in-service rank used by R3.
- R9: EOI strobes take effect only when `ack_i`=0. When both `seoi_i` and `eoi_i` are 1, only the specific EOI applies. The offset changes only through R5, R6 or R7.
- R10: While `rst_ni`=0, and independently of the clock, the request vector, the in-service vector, the offset and the edge history are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Interrupt request inputs |
| mask_i | input | 8 | Per-line mask, 1 blocks the line |
| level_i | input | 8 | Per-line trigger mode, 1 = level, 0 = edge |
| auto_eoi_i | input | 1 | Complete service at acknowledge |
| rot_auto_i | input | 1 | Rotate offset on auto completion |
| nested_i | input | 1 | Exclude cascade line from in-service rank |
| ack_i | input | 1 | Acknowledge strobe |
| eoi_i | input | 1 | Non-specific end-of-interrupt strobe |
| seoi_i | input | 1 | Specific end-of-interrupt strobe |
| seoi_idx_i | input | 3 | Line for specific end-of-interrupt |
| rot_eoi_i | input | 1 | Rotate offset on the EOI strobe |
| int_o | output | 1 | Interrupt request to the processor |
| ack_valid_o | output | 1 | Acknowledge accepted this cycle |
| ack_idx_o | output | 3 | Acknowledged line |
| irr_o | output | 8 | Request vector |
| isr_o | output | 8 | In-service vector |
| off_o | output | 3 | Priority offset |

## Verification
Several properties are checked on every cycle:
- An acknowledge is accepted only with a pending unmasked line.
- An accepted acknowledge marks that line in service, unless auto completion is on.
- In-service bits are never set without an acknowledge.
- A specific EOI always clears its bit.
- The offset holds still when no command arrives.

Other properties depend on the full ranking arithmetic and on history, so only the bench's scenarios can show them. These are the rotated priority order, the in-service exclusion for the cascade line in nested mode, edge detection against the previous sample, and command precedence. The bench compares each of these every cycle against its own model.

// File: rtl/rpr_pkg.sv
package rpr_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_ACK  = 2'd1,
    CMD_SEOI = 2'd2,
    CMD_EOI  = 2'd3
  } rpr_cmd_e;
endpackage

// File: rtl/rpr_req_capture.sv
module rpr_req_capture #(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic [NUM_LINES-1:0] level_i,
  input  logic [NUM_LINES-1:0] clr_i,
  output logic [NUM_LINES-1:0] irr_o
);
  logic [NUM_LINES-1:0] last_q;
  logic [NUM_LINES-1:0] irr_q;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        last_q[g] <= 1'b0;
        irr_q[g]  <= 1'b0;
      end else begin
        last_q[g] <= irq_i[g];
        if (level_i[g]) irr_q[g] <= irq_i[g];
        else            irr_q[g] <= (irr_q[g] & ~clr_i[g]) | (irq_i[g] & ~last_q[g]);
      end
    end
  end

  assign irr_o = irr_q;
endmodule

// File: rtl/rpr_rank_pick.sv
module rpr_rank_pick #(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = $clog2(NUM_LINES),
  parameter int RANK_W    = $clog2(NUM_LINES + 1)
) (
  input  logic [NUM_LINES-1:0] vec_i,
  input  logic [IDX_W-1:0]     off_i,
  output logic [RANK_W-1:0]    rank_o,
  output logic [IDX_W-1:0]     line_o
);
  int l;
  always_comb begin
    rank_o = RANK_W'(NUM_LINES);
    line_o = '0;
    l      = 0;
    for (int k = NUM_LINES - 1; k >= 0; k--) begin
      l = (k + int'(off_i)) % NUM_LINES;
      if (vec_i[l]) begin
        rank_o = RANK_W'(k);
        line_o = IDX_W'(l);
      end
    end
  end
endmodule

// File: rtl/rpr_core.sv
module rpr_core #(
  parameter int NUM_LINES    = 8,
  parameter int CASCADE_LINE = 2,
  parameter int IDX_W        = $clog2(NUM_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic [NUM_LINES-1:0] mask_i,
  input  logic [NUM_LINES-1:0] level_i,
  input  logic                 auto_eoi_i,
  input  logic                 rot_auto_i,
  input  logic                 nested_i,
  input  logic                 ack_i,
  input  logic                 eoi_i,
  input  logic                 seoi_i,
  input  logic [IDX_W-1:0]     seoi_idx_i,
  input  logic                 rot_eoi_i,
  output logic                 int_o,
  output logic                 ack_valid_o,
  output logic [IDX_W-1:0]     ack_idx_o,
  output logic [NUM_LINES-1:0] irr_o,
  output logic [NUM_LINES-1:0] isr_o,
  output logic [IDX_W-1:0]     off_o
);
  import rpr_pkg::*;

  localparam int RANK_W = $clog2(NUM_LINES + 1);
  localparam logic [RANK_W-1:0] RANK_EMPTY = RANK_W'(NUM_LINES);

  function automatic logic [IDX_W-1:0] next_line(input logic [IDX_W-1:0] x);
    return (int'(x) == NUM_LINES - 1) ? '0 : x + 1'b1;
  endfunction

  logic [NUM_LINES-1:0] irr, isr_q, isr_cmp, ack_clr, pend;
  logic [IDX_W-1:0]     off_q;
  logic [RANK_W-1:0]    pend_rank, cur_rank, top_rank;
  logic [IDX_W-1:0]     pend_line, top_line, cur_line_unused;
  rpr_cmd_e             cmd;

  assign pend = irr & ~mask_i;

  always_comb begin
    isr_cmp = isr_q;
    if (nested_i) isr_cmp[CASCADE_LINE] = 1'b0;
  end

  rpr_rank_pick #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .RANK_W(RANK_W)) u_pick_pend (
    .vec_i(pend), .off_i(off_q), .rank_o(pend_rank), .line_o(pend_line));
  rpr_rank_pick #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .RANK_W(RANK_W)) u_pick_cur (
    .vec_i(isr_cmp), .off_i(off_q), .rank_o(cur_rank), .line_o(cur_line_unused));
  rpr_rank_pick #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .RANK_W(RANK_W)) u_pick_top (
    .vec_i(isr_q), .off_i(off_q), .rank_o(top_rank), .line_o(top_line));

  assign int_o = pend_rank < cur_rank;

  // ack wins over EOI strobes; specific EOI wins over non-specific
  always_comb begin
    cmd = CMD_NONE;
    if (ack_i) begin
      if (int_o) cmd = CMD_ACK;
    end else if (seoi_i) begin
      cmd = CMD_SEOI;
    end else if (eoi_i && top_rank != RANK_EMPTY) begin
      cmd = CMD_EOI;
    end
  end

  assign ack_valid_o = (cmd == CMD_ACK);
  assign ack_idx_o   = pend_line;

  always_comb begin
    ack_clr = '0;
    if (cmd == CMD_ACK) ack_clr[pend_line] = ~level_i[pend_line];
  end

  rpr_req_capture #(.NUM_LINES(NUM_LINES)) u_capture (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i), .level_i(level_i),
    .clr_i(ack_clr), .irr_o(irr));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q <= '0;
      off_q <= '0;
    end else begin
      unique case (cmd)
        CMD_ACK: begin
          if (!auto_eoi_i)     isr_q[pend_line] <= 1'b1;
          else if (rot_auto_i) off_q <= next_line(pend_line);
        end
        CMD_SEOI: begin
          isr_q[seoi_idx_i] <= 1'b0;
          if (rot_eoi_i) off_q <= next_line(seoi_idx_i);
        end
        CMD_EOI: begin
          isr_q[top_line] <= 1'b0;
          if (rot_eoi_i) off_q <= next_line(top_line);
        end
        default: ;
      endcase
    end
  end

  assign irr_o = irr;
  assign isr_o = isr_q;
  assign off_o = off_q;
endmodule

// File: rtl/rpr_core_chk.sv
module rpr_core_chk #(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_LINES-1:0] mask_i,
  input logic                 auto_eoi_i,
  input logic                 ack_i,
  input logic                 eoi_i,
  input logic                 seoi_i,
  input logic [IDX_W-1:0]     seoi_idx_i,
  input logic                 int_o,
  input logic                 ack_valid_o,
  input logic [IDX_W-1:0]     ack_idx_o,
  input logic [NUM_LINES-1:0] irr_o,
  input logic [NUM_LINES-1:0] isr_o,
  input logic [IDX_W-1:0]     off_o
);
  AST_INT_NEEDS_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> (irr_o & ~mask_i) != '0); // R3

  AST_ACK_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_o |-> (ack_i && int_o)); // R4

  AST_ACK_LINE_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_o |-> (irr_o[ack_idx_o] && !mask_i[ack_idx_o])); // R4

  AST_ACK_SETS_ISR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_valid_o && !auto_eoi_i) |=> isr_o[$past(ack_idx_o)]); // R4

  AST_AUTO_KEEPS_ISR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_valid_o && auto_eoi_i) |=> isr_o == $past(isr_o)); // R5

  AST_NO_SPURIOUS_ISR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_valid_o |=> (isr_o & ~$past(isr_o)) == '0); // R4

  AST_SEOI_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seoi_i && !ack_i) |=> !isr_o[$past(seoi_idx_i)]); // R7

  AST_OFF_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_valid_o && (ack_i || (!eoi_i && !seoi_i))) |=> $stable(off_o)); // R9
endmodule

bind rpr_core rpr_core_chk #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mask_i(mask_i), .auto_eoi_i(auto_eoi_i),
  .ack_i(ack_i), .eoi_i(eoi_i), .seoi_i(seoi_i), .seoi_idx_i(seoi_idx_i),
  .int_o(int_o), .ack_valid_o(ack_valid_o), .ack_idx_o(ack_idx_o),
  .irr_o(irr_o), .isr_o(isr_o), .off_o(off_o));

// File: tb/rpr_core_bench.sv
`timescale 1ns/1ps
module rpr_core_bench;
  localparam int N = 8;
  localparam int CLK_P = 4;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic         rst_ni;
  logic [N-1:0] irq, mask, level;
  logic         auto_eoi, rot_auto, nested, ack, eoi, seoi, rot_eoi;
  logic [2:0]   seoi_idx;
  logic         int_o, ack_valid_o;
  logic [2:0]   ack_idx_o, off_o;
  logic [N-1:0] irr_o, isr_o;

  rpr_core u_rpr_core (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq), .mask_i(mask), .level_i(level),
    .auto_eoi_i(auto_eoi), .rot_auto_i(rot_auto), .nested_i(nested),
    .ack_i(ack), .eoi_i(eoi), .seoi_i(seoi), .seoi_idx_i(seoi_idx),
    .rot_eoi_i(rot_eoi), .int_o(int_o), .ack_valid_o(ack_valid_o),
    .ack_idx_o(ack_idx_o), .irr_o(irr_o), .isr_o(isr_o), .off_o(off_o));

  int checks = 0;
  int fails  = 0;
  logic [N-1:0] m_irr, m_isr, m_last;
  logic [2:0]   m_off;
  string        tag_st = "R10";

  function automatic int rank_f(logic [N-1:0] v, logic [2:0] o);
    for (int k = 0; k < N; k++) if (v[(k + int'(o)) % N]) return k;
    return N;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic clear_in();
    irq = '0; mask = '0; level = '0; auto_eoi = 0; rot_auto = 0; nested = 0;
    ack = 0; eoi = 0; seoi = 0; seoi_idx = '0; rot_eoi = 0;
  endtask

  task automatic model_reset();
    m_irr = '0; m_isr = '0; m_last = '0; m_off = '0; tag_st = "R10";
  endtask

  task automatic cycle();
    logic [N-1:0] pend, cmpv, n_irr;
    int pr, cr, pl, tr, tl;
    logic e_int;
    #1;
    pend = m_irr & ~mask;
    pr = rank_f(pend, m_off);
    cmpv = m_isr;
    if (nested) cmpv[2] = 1'b0;
    cr = rank_f(cmpv, m_off);
    e_int = (pr < cr);
    pl = (pr + int'(m_off)) % N;
    chk((nested && m_isr[2]) ? "R8" : "R3", "int_o", int'(int_o), int'(e_int));
    chk("R4", "ack_valid_o", int'(ack_valid_o), int'(ack && e_int));
    if (ack && e_int) chk("R4", "ack_idx_o", int'(ack_idx_o), pl);
    chk("R1", "irr_o edge lines", int'(irr_o & ~level), int'(m_irr & ~level));
    chk("R2", "irr_o level lines", int'(irr_o & level), int'(m_irr & level));
    chk(tag_st, "isr_o", int'(isr_o), int'(m_isr));
    chk(tag_st, "off_o", int'(off_o), int'(m_off));
    for (int i = 0; i < N; i++) begin
      if (level[i]) n_irr[i] = irq[i];
      else n_irr[i] = (m_irr[i] & ~(ack && e_int && pl == i)) | (irq[i] & ~m_last[i]);
    end
    m_last = irq;
    m_irr = n_irr;
    tag_st = "R4";
    if (ack) begin
      if (e_int) begin
        if (!auto_eoi) m_isr[pl] = 1'b1;
        else begin
          tag_st = "R5";
          if (rot_auto) m_off = 3'((pl + 1) % N);
        end
      end else if (eoi || seoi) tag_st = "R9";
    end else if (seoi) begin
      tag_st = eoi ? "R9" : "R7";
      m_isr[seoi_idx] = 1'b0;
      if (rot_eoi) m_off = 3'((int'(seoi_idx) + 1) % N);
    end else if (eoi) begin
      tag_st = "R6";
      tr = rank_f(m_isr, m_off);
      if (tr < N) begin
        tl = (tr + int'(m_off)) % N;
        m_isr[tl] = 1'b0;
        if (rot_eoi) m_off = 3'((tl + 1) % N);
      end
    end
    @(negedge clk);
  endtask

  task automatic idle(int n);
    ack = 0; eoi = 0; seoi = 0;
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    #1;
    chk("R10", "irr_o reset", int'(irr_o), 0);
    chk("R10", "isr_o reset", int'(isr_o), 0);
    chk("R10", "off_o reset", int'(off_o), 0);
    chk("R10", "int_o reset", int'(int_o), 0);
    @(negedge clk);
    model_reset();
    rst_ni = 1'b1;
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20251));
    clear_in();
    @(negedge clk);
    do_reset();

    // R1: edge line 5, held high after acknowledge must not re-request
    irq[5] = 1; idle(2);
    ack = 1; cycle(); ack = 0; idle(3);
    eoi = 1; cycle(); eoi = 0; idle(1);
    irq[5] = 0; idle(1); irq[5] = 1; idle(2);
    ack = 1; cycle(); eoi = 1; ack = 0; cycle(); eoi = 0; idle(1);

    // R2: level line 3 keeps request through acknowledge, drops with input
    level[3] = 1; irq[3] = 1; idle(2);
    ack = 1; cycle(); ack = 0; idle(1);
    irq[3] = 0; idle(2);
    seoi = 1; seoi_idx = 3; cycle(); seoi = 0; idle(1);

    // R3: masked line ignored, lower line outranked by in-service
    irq = 8'h0C; mask = 8'h04; idle(2);
    ack = 1; cycle(); ack = 0; idle(1);
    mask = 8'h00; idle(2);
    ack = 1; cycle(); ack = 0; idle(1);
    irq = 8'h00; level = '0;
    eoi = 1; cycle(); cycle(); cycle(); eoi = 0; idle(1);

    // R8: nested mode lets a cascade request through while it is in service
    irq[2] = 1; idle(2); ack = 1; cycle(); ack = 0; irq[2] = 0; idle(1);
    irq[2] = 1; idle(2); nested = 1; idle(1);
    ack = 1; cycle(); ack = 0; nested = 0; idle(1);
    eoi = 1; cycle(); cycle(); eoi = 0; irq = '0; idle(1);

    // R6/R7: rotating EOI and specific rotate
    irq = 8'hFF; idle(2);
    ack = 1; cycle(); ack = 0;
    rot_eoi = 1; eoi = 1; cycle(); eoi = 0; idle(1);
    seoi = 1; seoi_idx = 3'd6; cycle(); seoi = 0; rot_eoi = 0; idle(1);
    irq = '0; idle(2);

    // R5: auto completion with rotation
    auto_eoi = 1; rot_auto = 1; irq = 8'h90; idle(2);
    ack = 1; cycle(); cycle(); ack = 0; idle(1);
    auto_eoi = 0; rot_auto = 0; irq = '0; idle(2);

    // R9: precedence of strobes
    irq = 8'h21; idle(2); ack = 1; cycle(); cycle();
    eoi = 1; seoi = 1; seoi_idx = 3'd5; cycle();
    ack = 0; rot_eoi = 1; cycle(); seoi = 0; cycle(); eoi = 0; rot_eoi = 0; idle(2);

    // R10: asynchronous reset mid-stream
    irq = 8'h44; idle(2); ack = 1; cycle(); ack = 0;
    do_reset(); clear_in(); idle(2);

    for (int blk = 0; blk < 20; blk++) begin
      level    = 8'($urandom);
      mask     = 8'($urandom) & 8'($urandom) & 8'($urandom);
      auto_eoi = ($urandom % 4) == 0;
      rot_auto = $urandom % 2;
      nested   = $urandom % 2;
      for (int c = 0; c < 150; c++) begin
        irq     ^= 8'($urandom) & 8'($urandom) & 8'($urandom);
        ack      = ($urandom % 3) == 0;
        eoi      = ($urandom % 5) == 0;
        seoi     = ($urandom % 7) == 0;
        seoi_idx = 3'($urandom);
        rot_eoi  = $urandom % 2;
        cycle();
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule